// File: doc/BRIEF.md
# Circular Return Address Stack

This block predicts the targets of subroutine returns. Each time the front end sees a call it pushes the return address. Each time it sees a return it pops, and it uses the address that was on top as its predicted target. Storage is a ring of address-wide slots. A top-of-stack index moves around the ring and wraps at both ends, so a stack that is already full takes a new push by overwriting its oldest slot instead of refusing it. A count of live entries drives the empty and full flags.

The current top index is an output, so the predictor can save it next to each speculative branch. When a branch turns out to be mispredicted, the restore command returns the index to the saved value and writes the corrected target into that slot. This repairs the one entry that a wrong-path call or return is most likely to have damaged. The top address is read combinationally from the slot under the index, so a change made on one clock edge shows on the output in the following cycle.

Top module: `retaddr_stack`

## Requirements
- R1: A synchronous active-high reset clears every slot to zero and clears the top index and the live count. After reset the top address is 0, the top index is 0, empty is 1 and full is 0.
- R2: A push first advances the top index by one, wrapping from DEPTH-1 to 0. It then stores the pushed address in the slot at the new index, and that address appears on the top address output in the next cycle.
- R3: A push raises the live count by one, and the count saturates at DEPTH. A push while full still advances the index and overwrites the oldest slot, and full stays 1.
- R4: A pop moves the top index back by one, wrapping from 0 to DEPTH-1. It lowers the live count by one when the count is nonzero. After a pop, the top address shows the slot at the new index.
- R5: A pop while empty still moves the top index back by one, but the count stays at zero and empty stays 1.
- R6: A restore sets the top index to the supplied index, which must be below DEPTH, and writes the supplied target into that slot. The live count, and so both flags, are left unchanged.
- R7: When several commands arrive in one cycle, restore wins over push and push wins over pop. Only the winning command has any effect.
- R8: With no command, the index, the count and every slot hold their values. The top address is always the content of the slot under the current top index.
- R9: Empty is 1 exactly when the live count is zero, and full is 1 exactly when it equals DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| push_i | input | 1 | Push command |
| push_addr_i | input | ADDR_W | Return address to push |
| pop_i | input | 1 | Pop command |
| restore_i | input | 1 | Misprediction repair command |
| restore_idx_i | input | IDX_W | Top index to return to |
| restore_addr_i | input | ADDR_W | Corrected target written at the restored index |
| top_addr_o | output | ADDR_W | Address in the slot under the top index |
| top_idx_o | output | IDX_W | Current top-of-stack index |
| empty_o | output | 1 | No live entries |
| full_o | output | 1 | Live count equals DEPTH |

## Verification
The assertions assume that a restore index is always below DEPTH. They check this as an input rule rather than as design behaviour. They also assume that command inputs are driven to known values whenever reset is low. The bench uses a depth of five, so the index has encodings that are never legal. Every restore index it generates, whether from the directed sweep or the pseudo-random phase, is reduced modulo five, and all commands change only at the falling clock edge.

// File: rtl/retaddr_pkg.sv
`timescale 1ns/1ps
package retaddr_pkg;

    typedef enum logic [1:0] {
        OP_IDLE    = 2'd0,
        OP_PUSH    = 2'd1,
        OP_POP     = 2'd2,
        OP_RESTORE = 2'd3
    } ras_op_e;

    // Ring successor of an index for a ring of the given size
    function automatic int ring_next(input int idx, input int size);
        return (idx >= size - 1) ? 0 : idx + 1;
    endfunction

    // Ring predecessor of an index for a ring of the given size
    function automatic int ring_prev(input int idx, input int size);
        return (idx == 0) ? size - 1 : idx - 1;
    endfunction

    function automatic int idx_bits(input int size);
        return (size > 1) ? $clog2(size) : 1;
    endfunction

endpackage

// File: rtl/retaddr_cmd_arb.sv
`timescale 1ns/1ps
module retaddr_cmd_arb
    import retaddr_pkg::*;
(
    input  logic    push_i,
    input  logic    pop_i,
    input  logic    restore_i,
    output ras_op_e op_o
);
    // Fixed priority: restore, then push, then pop
    always_comb begin
        if (restore_i)   op_o = OP_RESTORE;
        else if (push_i) op_o = OP_PUSH;
        else if (pop_i)  op_o = OP_POP;
        else             op_o = OP_IDLE;
    end
endmodule

// File: rtl/retaddr_ptr.sv
`timescale 1ns/1ps
module retaddr_ptr
    import retaddr_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int IDX_W = 4,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  ras_op_e          op_i,
    input  logic [IDX_W-1:0] restore_idx_i,
    output logic [IDX_W-1:0] tos_o,
    output logic             wr_en_o,
    output logic [IDX_W-1:0] wr_idx_o,
    output logic             empty_o,
    output logic             full_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

    logic [IDX_W-1:0] tos_q, tos_d, tos_up, tos_dn;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    assign tos_up = IDX_W'(ring_next(32'(tos_q), DEPTH));
    assign tos_dn = IDX_W'(ring_prev(32'(tos_q), DEPTH));

    always_comb begin
        tos_d    = tos_q;
        cnt_d    = cnt_q;
        wr_en_o  = 1'b0;
        wr_idx_o = tos_up;
        unique case (op_i)
            OP_RESTORE: begin
                tos_d    = restore_idx_i;
                wr_en_o  = 1'b1;
                wr_idx_o = restore_idx_i;
            end
            OP_PUSH: begin
                tos_d    = tos_up;
                wr_en_o  = 1'b1;
                wr_idx_o = tos_up;
                if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
            end
            OP_POP: begin
                tos_d = tos_dn;
                if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tos_q <= '0;
            cnt_q <= '0;
        end else begin
            tos_q <= tos_d;
            cnt_q <= cnt_d;
        end
    end

    assign tos_o   = tos_q;
    assign empty_o = (cnt_q == '0);
    assign full_o  = (cnt_q == CNT_MAX);
endmodule

// File: rtl/retaddr_store.sv
`timescale 1ns/1ps
module retaddr_store #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [ADDR_W-1:0] wr_data_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic [ADDR_W-1:0] rd_data_o
);
    logic [ADDR_W-1:0] slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                slot_q[g] <= '0;
            else if (wr_en_i && (wr_idx_i == IDX_W'(g)))
                slot_q[g] <= wr_data_i;
        end
    end

    assign rd_data_o = slot_q[rd_idx_i];
endmodule

// File: rtl/retaddr_stack.sv
`timescale 1ns/1ps
module retaddr_stack
    import retaddr_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 32,
    localparam int IDX_W = idx_bits(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_i,
    input  logic [ADDR_W-1:0] push_addr_i,
    input  logic              pop_i,
    input  logic              restore_i,
    input  logic [IDX_W-1:0]  restore_idx_i,
    input  logic [ADDR_W-1:0] restore_addr_i,
    output logic [ADDR_W-1:0] top_addr_o,
    output logic [IDX_W-1:0]  top_idx_o,
    output logic              empty_o,
    output logic              full_o
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    ras_op_e           op;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [ADDR_W-1:0] wr_data;

    retaddr_cmd_arb u_arb (
        .push_i    (push_i),
        .pop_i     (pop_i),
        .restore_i (restore_i),
        .op_o      (op)
    );

    retaddr_ptr #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_ptr (
        .clk           (clk),
        .rst           (rst),
        .op_i          (op),
        .restore_idx_i (restore_idx_i),
        .tos_o         (top_idx_o),
        .wr_en_o       (wr_en),
        .wr_idx_o      (wr_idx),
        .empty_o       (empty_o),
        .full_o        (full_o)
    );

    assign wr_data = (op == OP_RESTORE) ? restore_addr_i : push_addr_i;

    retaddr_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (wr_en),
        .wr_idx_i  (wr_idx),
        .wr_data_i (wr_data),
        .rd_idx_i  (top_idx_o),
        .rd_data_o (top_addr_o)
    );
endmodule

// File: rtl/retaddr_stack_chk.sv
`timescale 1ns/1ps
module retaddr_stack_chk
    import retaddr_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 32,
    localparam int IDX_W = idx_bits(DEPTH)
) (
    input logic              clk,
    input logic              rst,
    input logic              push_i,
    input logic [ADDR_W-1:0] push_addr_i,
    input logic              pop_i,
    input logic              restore_i,
    input logic [IDX_W-1:0]  restore_idx_i,
    input logic [ADDR_W-1:0] restore_addr_i,
    input logic [ADDR_W-1:0] top_addr_o,
    input logic [IDX_W-1:0]  top_idx_o,
    input logic              empty_o,
    input logic              full_o
);
    // R2: push moves the index forward and shows the new address
    a_r2_push_advance: assert property (@(posedge clk) disable iff (rst)
        (push_i && !restore_i) |=>
            (top_idx_o == IDX_W'(ring_next(32'($past(top_idx_o)), DEPTH)))
            && (top_addr_o == $past(push_addr_i)));

    // R3: full persists across an overwriting push
    a_r3_full_holds: assert property (@(posedge clk) disable iff (rst)
        (full_o && push_i && !restore_i) |=> full_o);

    // R3: any push leaves at least one live entry
    a_r3_push_not_empty: assert property (@(posedge clk) disable iff (rst)
        (push_i && !restore_i) |=> !empty_o);

    // R4: a lone pop moves the index back and clears full
    a_r4_pop_retreat: assert property (@(posedge clk) disable iff (rst)
        (pop_i && !push_i && !restore_i) |=>
            (top_idx_o == IDX_W'(ring_prev(32'($past(top_idx_o)), DEPTH)))
            && !full_o);

    // R5: pop on empty keeps empty
    a_r5_empty_pop: assert property (@(posedge clk) disable iff (rst)
        (empty_o && pop_i && !push_i && !restore_i) |=> empty_o);

    // R6: restore index must be legal (input rule)
    a_r6_idx_legal: assert property (@(posedge clk) disable iff (rst)
        restore_i |-> (32'(restore_idx_i) < DEPTH));

    // R6 and R7: restore wins, repairs the slot and keeps the flags
    a_r6_restore: assert property (@(posedge clk) disable iff (rst)
        restore_i |=>
            (top_idx_o == $past(restore_idx_i))
            && (top_addr_o == $past(restore_addr_i))
            && (empty_o == $past(empty_o))
            && (full_o == $past(full_o)));

    // R8: no command, no change
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!push_i && !pop_i && !restore_i) |=>
            $stable(top_idx_o) && $stable(top_addr_o)
            && $stable(empty_o) && $stable(full_o));

    // R9: flags are exclusive
    a_r9_flags_excl: assert property (@(posedge clk) disable iff (rst)
        !(empty_o && full_o));
endmodule

bind retaddr_stack retaddr_stack_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .push_i         (push_i),
    .push_addr_i    (push_addr_i),
    .pop_i          (pop_i),
    .restore_i      (restore_i),
    .restore_idx_i  (restore_idx_i),
    .restore_addr_i (restore_addr_i),
    .top_addr_o     (top_addr_o),
    .top_idx_o      (top_idx_o),
    .empty_o        (empty_o),
    .full_o         (full_o)
);

// File: tb/retaddr_stack_bench.sv
`timescale 1ns/1ps
module retaddr_stack_bench;
    localparam int D  = 5;
    localparam int AW = 16;
    localparam int IW = (D > 1) ? $clog2(D) : 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          push = 1'b0, pop = 1'b0, rsto = 1'b0;
    logic [AW-1:0] push_addr = '0, rsto_addr = '0;
    logic [IW-1:0] rsto_idx = '0;
    logic [AW-1:0] top_addr;
    logic [IW-1:0] top_idx;
    logic          empty, full;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [AW-1:0] m_slot [D];
    int m_tos, m_cnt;

    always #2.5 clk = ~clk;

    retaddr_stack #(.DEPTH(D), .ADDR_W(AW)) u_retaddr_stack (
        .clk            (clk),
        .rst            (rst),
        .push_i         (push),
        .push_addr_i    (push_addr),
        .pop_i          (pop),
        .restore_i      (rsto),
        .restore_idx_i  (rsto_idx),
        .restore_addr_i (rsto_addr),
        .top_addr_o     (top_addr),
        .top_idx_o      (top_idx),
        .empty_o        (empty),
        .full_o         (full)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        check(top_addr == m_slot[m_tos], tag, "top address", int'(top_addr), int'(m_slot[m_tos]));
        check(int'(top_idx) == m_tos, tag, "top index", int'(top_idx), m_tos);
        check(empty == (m_cnt == 0), {tag, " R9"}, "empty flag", int'(empty), int'(m_cnt == 0));
        check(full == (m_cnt == D), {tag, " R9"}, "full flag", int'(full), int'(m_cnt == D));
    endtask

    task automatic model_reset();
        for (int i = 0; i < D; i++) m_slot[i] = '0;
        m_tos = 0;
        m_cnt = 0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        push = 0; pop = 0; rsto = 0;
        repeat (3) @(posedge clk);
        model_reset();
        @(negedge clk);
        rst = 1'b0;
        compare("R1");
    endtask

    // Drive at the falling edge, update the model at the rising edge,
    // compare at the next falling edge.
    task automatic step(input bit p, input bit po, input bit r, input int idx,
                        input logic [AW-1:0] a, input string tag);
        push = p; pop = po; rsto = r;
        push_addr = a;
        rsto_addr = ~a;
        rsto_idx = IW'(idx);
        @(posedge clk);
        if (r) begin
            m_tos = idx;
            m_slot[idx] = ~a;
        end else if (p) begin
            m_tos = (m_tos + 1) % D;
            m_slot[m_tos] = a;
            if (m_cnt < D) m_cnt++;
        end else if (po) begin
            m_tos = (m_tos + D - 1) % D;
            if (m_cnt > 0) m_cnt--;
        end
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        logic [31:0] lcg;
        model_reset();
        @(negedge clk);
        do_reset();

        // R1 and R5: every slot reads zero after reset; pops on empty wrap the index
        for (int k = 0; k < D + 1; k++) step(0, 1, 0, 0, '0, "R5");
        check(empty == 1'b1, "R5", "empty after underflow", int'(empty), 1);

        do_reset();
        // R2 then R3: fill, then overflow and overwrite the oldest slots
        for (int k = 0; k < D + 3; k++)
            step(1, 0, 0, 0, AW'(16'h1000 + k * 16'h0111), (k < D) ? "R2" : "R3");
        check(full == 1'b1, "R3", "full after overflow", int'(full), 1);

        // R4 down to empty, then R5 beyond
        for (int k = 0; k < D + 2; k++) step(0, 1, 0, 0, '0, (k < D) ? "R4" : "R5");

        // R6: restore every legal index, flags untouched
        for (int i = 0; i < D; i++) step(0, 0, 1, i, AW'(16'h5A00 + i), "R6");
        for (int i = 0; i < 2; i++) step(1, 0, 0, 0, AW'(16'h7700 + i), "R2");
        for (int i = D - 1; i >= 0; i--) step(0, 0, 1, i, AW'(16'h3300 + i), "R6");

        // R7 and R8: every command combination, several times
        for (int rep = 0; rep < 6; rep++)
            for (int c = 0; c < 8; c++)
                step(c[0], c[1], c[2], (c * 3 + rep) % D,
                     AW'(16'hC000 + rep * 16 + c), (c == 0) ? "R8" : "R7");

        // R8: long pseudo-random run
        lcg = 32'h1234_5678;
        for (int k = 0; k < 600; k++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            step(lcg[20], lcg[21], lcg[22] & lcg[23], int'(lcg[15:8]) % D,
                 lcg[31:16], "R8");
        end

        do_reset();
        push = 0; pop = 0; rsto = 0;
        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R8: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule